// File: doc/BRIEF.md
# Shared Cell Buffer Admission Accounting

This block keeps the occupancy books for one slice of a shared packet buffer that is carved into fixed 208-byte cells. Each arriving packet is described by its byte length, a 4-bit service class, a unicast/multicast flag and an ingress port. The block converts the length into a cell count. It routes the packet to one of four cell groups that never lend cells to each other: ingress reserve, user-class egress, CPU and SPAN. It checks the group total and the finer pool or port counter against the limits of the active partition table, and returns admit or drop with a fixed two-cycle latency. Admitted cells are charged at once.

A release port returns cells when packets leave the buffer. A release that arrives in the same cycle as a request is applied first, so the request can use the freed cells. A single mode input selects between the default partition and a lossless partition. In the lossless partition, a parameterised set of up to three no-drop classes is charged against an ingress reserve that is split evenly among the ingress ports. The mode can only change while the buffer is empty. Releases that would take a counter below zero are clamped and reported through a sticky flag.

Top module: `cell_admit_acct`

## Requirements
- R1: A request of length L bytes needs ceil(L/208) cells, and a length of 0 counts as one cell; that count is reported on `resCells` with every result, whether admitted or dropped.
- R2: A request sampled on a clock edge produces a one-cycle `resValid` pulse two edges later, and `resValid` is low in the cycle between.
- R3: Class codes 0..7 are user classes, charged to user pool index 2*class+mcast; code 8 is SPAN, code 9 is CPU; codes 10..15 are always dropped and charge nothing.
- R4: A request is admitted only if the occupancy of its group, after the cells are added, stays at or below that group's limit. A full group never takes cells from another group.
- R5: A user-class request is also dropped if its own pool would exceed the user-group limit shifted right by POOL_SHIFT.
- R6: In lossless mode, a class whose bit is set in NODROP_MASK is charged to the ingress group, whose limit is LL_ING. Its ingress port may hold no more than LL_ING/NUM_PORTS cells.
- R7: In default mode, the limits are DEF_ING / DEF_USER / CPU_CELLS / SPAN_CELLS and no-drop classes are charged like any user class. In lossless mode, the limits are LL_ING / LL_USER / CPU_CELLS / SPAN_CELLS.
- R8: A dropped request leaves every counter unchanged.
- R9: A release of N cells for a class, flag and port reduces the matching group counter and the matching pool or port counter by N. A release and a request in the same cycle are both applied, with the release counted before the admission check.
- R10: A release larger than a counter's value clamps that counter at zero (no wrap) and sets `underflowFlag`, which stays set until reset.
- R11: `modeActive` follows `modeReq` only when every counter is zero and no request is in flight. Otherwise the change is ignored and the sticky `modeErr` flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| modeReq | input | 1 | Requested partition: 0 default, 1 lossless |
| reqValid | input | 1 | Admission request strobe |
| reqLen | input | LEN_W | Packet length in bytes |
| reqClass | input | 4 | Service class code |
| reqMcast | input | 1 | 1 for multicast, 0 for unicast |
| reqPort | input | PORT_W | Ingress port |
| relValid | input | 1 | Release strobe |
| relCells | input | CELL_W | Cells returned |
| relClass | input | 4 | Class of the released cells |
| relMcast | input | 1 | Multicast flag of the released cells |
| relPort | input | PORT_W | Ingress port of the released cells |
| resValid | output | 1 | Result pulse |
| resAdmit | output | 1 | 1 admit, 0 drop |
| resCells | output | CELL_W | Cells the request needed |
| modeActive | output | 1 | Partition table in force |
| modeErr | output | 1 | Sticky: mode change refused |
| underflowFlag | output | 1 | Sticky: release exceeded a counter |

## Verification
The hardest case to reach from the ports is a limit boundary that is hit while a release is applied in the same cycle. To get there, a counter has to be filled exactly to its limit and the release has to line up with a request that only fits once the freed cell is counted. The stimulus table fills the CPU group to its limit, confirms a drop, then issues a one-cell release together with a one-cell request and expects an admit. Small limit overrides keep every boundary, including the per-port ingress cap and the refused mode change, reachable in a few dozen requests.

// File: rtl/cba_pkg.sv
package cba_pkg;

  localparam int USER_CLASSES = 8;
  localparam int NUM_GROUPS   = 4;
  localparam int G_ING  = 0;
  localparam int G_USER = 1;
  localparam int G_CPU  = 2;
  localparam int G_SPAN = 3;

  localparam logic [3:0] CLS_SPAN = 4'd8;
  localparam logic [3:0] CLS_CPU  = 4'd9;

  typedef enum logic [2:0] {
    GRP_ING  = 3'd0,
    GRP_USER = 3'd1,
    GRP_CPU  = 3'd2,
    GRP_SPAN = 3'd3,
    GRP_NONE = 3'd4
  } grp_e;

  typedef struct packed {
    logic s1Req;
    logic s1Rel;
    logic lossless;
  } ctrl_t;

  function automatic grp_e routeClass(input logic [3:0] cls,
                                      input logic lossless,
                                      input logic [USER_CLASSES-1:0] noDropMask);
    grp_e g;
    if (cls < 4'd8) begin
      g = (lossless && noDropMask[cls[2:0]]) ? GRP_ING : GRP_USER;
    end else if (cls == CLS_SPAN) begin
      g = GRP_SPAN;
    end else if (cls == CLS_CPU) begin
      g = GRP_CPU;
    end else begin
      g = GRP_NONE;
    end
    return g;
  endfunction

endpackage

// File: rtl/cba_counter.sv
module cba_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] decAmt,
  input  logic [W-1:0] incAmt,
  output logic [W-1:0] count,
  output logic [W-1:0] afterRel,
  output logic         underflow
);

  assign underflow = decAmt > count;
  assign afterRel  = underflow ? '0 : count - decAmt;

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= afterRel + incAmt;
  end

  // R10: an oversize release leaves only what was charged in the same cycle
  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> count == $past(incAmt));

endmodule

// File: rtl/cba_ctrl.sv
module cba_ctrl
  import cba_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  reqValid,
  input  logic  relValid,
  input  logic  modeReq,
  input  logic  allZero,
  output ctrl_t ctl,
  output logic  resValid,
  output logic  modeErr
);

  logic s1Req;
  logic s1Rel;
  logic lossless;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Req    <= 1'b0;
      s1Rel    <= 1'b0;
      resValid <= 1'b0;
      lossless <= 1'b0;
      modeErr  <= 1'b0;
    end else begin
      s1Req    <= reqValid;
      s1Rel    <= relValid;
      resValid <= s1Req;
      if (modeReq != lossless) begin
        if (allZero && !s1Req) lossless <= modeReq;
        else                   modeErr  <= 1'b1;
      end
    end
  end

  assign ctl.s1Req    = s1Req;
  assign ctl.s1Rel    = s1Rel;
  assign ctl.lossless = lossless;

  // R11: the partition table only moves while the buffer is empty and idle
  a_r11_mode_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lossless) |-> ($past(allZero) && !$past(s1Req)));

  // R11: a refused change is remembered
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    modeErr |=> modeErr);

  // R2: each result pulse answers a request two edges earlier
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |-> $past(reqValid, 2));

endmodule

// File: rtl/cba_datapath.sv
module cba_datapath
  import cba_pkg::*;
#(
  parameter int LEN_W       = 14,
  parameter int CELL_BYTES  = 208,
  parameter int NUM_PORTS   = 4,
  parameter int POOL_SHIFT  = 2,
  parameter int DEF_ING     = 2000,
  parameter int DEF_USER    = 19000,
  parameter int LL_ING      = 8000,
  parameter int LL_USER     = 10000,
  parameter int CPU_CELLS   = 1500,
  parameter int SPAN_CELLS  = 1500,
  parameter logic [USER_CLASSES-1:0] NODROP_MASK = 8'h08,
  parameter int CELL_W      = 7,
  parameter int PORT_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctl,
  input  logic              reqValid,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [3:0]        reqClass,
  input  logic              reqMcast,
  input  logic [PORT_W-1:0] reqPort,
  input  logic              relValid,
  input  logic [CELL_W-1:0] relCells,
  input  logic [3:0]        relClass,
  input  logic              relMcast,
  input  logic [PORT_W-1:0] relPort,
  output logic              allZero,
  output logic              resAdmit,
  output logic [CELL_W-1:0] resCells,
  output logic              underflowFlag
);

  localparam int POOLS     = 2 * USER_CLASSES;
  localparam int POOL_W    = $clog2(POOLS);
  localparam int MAX_CELLS = ((1 << LEN_W) - 1 + CELL_BYTES - 1) / CELL_BYTES;
  localparam int DEF_SUM   = DEF_ING + DEF_USER;
  localparam int LL_SUM    = LL_ING + LL_USER;
  localparam int MAX_TOTAL = ((DEF_SUM > LL_SUM) ? DEF_SUM : LL_SUM) + CPU_CELLS + SPAN_CELLS;
  localparam int BIGGEST   = (MAX_TOTAL > MAX_CELLS) ? MAX_TOTAL : MAX_CELLS;
  localparam int CNT_W     = $clog2(BIGGEST + 1) + 1;

  function automatic logic [CELL_W-1:0] cellsFor(input logic [LEN_W-1:0] len);
    logic [LEN_W:0] padded;
    logic [LEN_W:0] quot;
    padded = {1'b0, len} + (LEN_W+1)'(CELL_BYTES - 1);
    quot   = padded / (LEN_W+1)'(CELL_BYTES);
    if (len == '0) return CELL_W'(1);
    return CELL_W'(quot);
  endfunction

  function automatic logic fitsIn(input logic [CNT_W-1:0] occ,
                                  input logic [CNT_W-1:0] add,
                                  input logic [CNT_W-1:0] lim);
    return ({1'b0, occ} + {1'b0, add}) <= {1'b0, lim};
  endfunction

  // stage 1 captures
  logic [CELL_W-1:0] s1Cells;
  logic [3:0]        s1Class;
  logic              s1Mcast;
  logic [PORT_W-1:0] s1Port;
  logic [CELL_W-1:0] rlCells;
  logic [3:0]        rlClass;
  logic              rlMcast;
  logic [PORT_W-1:0] rlPort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Cells <= '0;
      s1Class <= '0;
      s1Mcast <= 1'b0;
      s1Port  <= '0;
      rlCells <= '0;
      rlClass <= '0;
      rlMcast <= 1'b0;
      rlPort  <= '0;
    end else begin
      if (reqValid) begin
        s1Cells <= cellsFor(reqLen);
        s1Class <= reqClass;
        s1Mcast <= reqMcast;
        s1Port  <= reqPort;
      end
      if (relValid) begin
        rlCells <= relCells;
        rlClass <= relClass;
        rlMcast <= relMcast;
        rlPort  <= relPort;
      end
    end
  end

  grp_e reqGrp;
  grp_e relGrp;
  logic [POOL_W-1:0] reqPool;
  logic [POOL_W-1:0] relPool;
  logic [CNT_W-1:0]  cellsN;
  logic [CNT_W-1:0]  relN;

  assign reqGrp  = routeClass(s1Class, ctl.lossless, NODROP_MASK);
  assign relGrp  = routeClass(rlClass, ctl.lossless, NODROP_MASK);
  assign reqPool = {s1Class[2:0], s1Mcast};
  assign relPool = {rlClass[2:0], rlMcast};
  assign cellsN  = CNT_W'(s1Cells);
  assign relN    = CNT_W'(rlCells);

  // limits of the active partition table
  logic [CNT_W-1:0] grpLim [NUM_GROUPS];
  logic [CNT_W-1:0] poolLim;
  logic [CNT_W-1:0] portLim;

  always_comb begin
    grpLim[G_ING]  = ctl.lossless ? CNT_W'(LL_ING)  : CNT_W'(DEF_ING);
    grpLim[G_USER] = ctl.lossless ? CNT_W'(LL_USER) : CNT_W'(DEF_USER);
    grpLim[G_CPU]  = CNT_W'(CPU_CELLS);
    grpLim[G_SPAN] = CNT_W'(SPAN_CELLS);
    poolLim        = grpLim[G_USER] >> POOL_SHIFT;
    portLim        = ctl.lossless ? CNT_W'(LL_ING / NUM_PORTS) : CNT_W'(DEF_ING / NUM_PORTS);
  end

  // counters
  logic [CNT_W-1:0] grpDec [NUM_GROUPS];
  logic [CNT_W-1:0] grpInc [NUM_GROUPS];
  logic [CNT_W-1:0] grpCnt [NUM_GROUPS];
  logic [CNT_W-1:0] grpAfter [NUM_GROUPS];
  logic             grpUf [NUM_GROUPS];
  logic [CNT_W-1:0] poolDec [POOLS];
  logic [CNT_W-1:0] poolInc [POOLS];
  logic [CNT_W-1:0] poolCnt [POOLS];
  logic [CNT_W-1:0] poolAfter [POOLS];
  logic             poolUf [POOLS];
  logic [CNT_W-1:0] portDec [NUM_PORTS];
  logic [CNT_W-1:0] portInc [NUM_PORTS];
  logic [CNT_W-1:0] portCnt [NUM_PORTS];
  logic [CNT_W-1:0] portAfter [NUM_PORTS];
  logic             portUf [NUM_PORTS];

  logic fits;
  logic admit;

  always_comb begin
    fits = 1'b0;
    case (reqGrp)
      GRP_ING:  fits = fitsIn(grpAfter[G_ING], cellsN, grpLim[G_ING]) &&
                       fitsIn(portAfter[s1Port], cellsN, portLim);
      GRP_USER: fits = fitsIn(grpAfter[G_USER], cellsN, grpLim[G_USER]) &&
                       fitsIn(poolAfter[reqPool], cellsN, poolLim);
      GRP_CPU:  fits = fitsIn(grpAfter[G_CPU], cellsN, grpLim[G_CPU]);
      GRP_SPAN: fits = fitsIn(grpAfter[G_SPAN], cellsN, grpLim[G_SPAN]);
      default:  fits = 1'b0;
    endcase
  end

  assign admit = ctl.s1Req && fits;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grpDec[g] = (ctl.s1Rel && relGrp == grp_e'(g)) ? relN : '0;
    assign grpInc[g] = (admit && reqGrp == grp_e'(g)) ? cellsN : '0;
    cba_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .decAmt(grpDec[g]), .incAmt(grpInc[g]),
      .count(grpCnt[g]), .afterRel(grpAfter[g]), .underflow(grpUf[g])
    );
    // R4: no group ever holds more than its table limit
    a_r4_group_limit: assert property (@(posedge clk) disable iff (!rst_n)
      grpCnt[g] <= grpLim[g]);
  end

  for (genvar p = 0; p < POOLS; p++) begin : g_pool
    assign poolDec[p] = (ctl.s1Rel && relGrp == GRP_USER && relPool == POOL_W'(p)) ? relN : '0;
    assign poolInc[p] = (admit && reqGrp == GRP_USER && reqPool == POOL_W'(p)) ? cellsN : '0;
    cba_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .decAmt(poolDec[p]), .incAmt(poolInc[p]),
      .count(poolCnt[p]), .afterRel(poolAfter[p]), .underflow(poolUf[p])
    );
    // R5: each user pool stays within its share
    a_r5_pool_limit: assert property (@(posedge clk) disable iff (!rst_n)
      poolCnt[p] <= poolLim);
  end

  for (genvar q = 0; q < NUM_PORTS; q++) begin : g_port
    assign portDec[q] = (ctl.s1Rel && relGrp == GRP_ING && rlPort == PORT_W'(q)) ? relN : '0;
    assign portInc[q] = (admit && reqGrp == GRP_ING && s1Port == PORT_W'(q)) ? cellsN : '0;
    cba_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .decAmt(portDec[q]), .incAmt(portInc[q]),
      .count(portCnt[q]), .afterRel(portAfter[q]), .underflow(portUf[q])
    );
    // R6: per-port share of the ingress reserve
    a_r6_port_limit: assert property (@(posedge clk) disable iff (!rst_n)
      portCnt[q] <= portLim);
  end

  logic ufNow;
  logic [CNT_W+1:0] totalOcc;

  always_comb begin
    ufNow    = 1'b0;
    allZero  = 1'b1;
    totalOcc = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      ufNow    |= grpUf[g];
      allZero  &= (grpCnt[g] == '0);
      totalOcc += (CNT_W+2)'(grpCnt[g]);
    end
    for (int p = 0; p < POOLS; p++) begin
      ufNow   |= poolUf[p];
      allZero &= (poolCnt[p] == '0);
    end
    for (int q = 0; q < NUM_PORTS; q++) begin
      ufNow   |= portUf[q];
      allZero &= (portCnt[q] == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resAdmit      <= 1'b0;
      resCells      <= '0;
      underflowFlag <= 1'b0;
    end else begin
      if (ctl.s1Req) begin
        resAdmit <= admit;
        resCells <= s1Cells;
      end
      if (ufNow) underflowFlag <= 1'b1;
    end
  end

  // R8: a drop with no release in the same cycle leaves the books untouched
  a_r8_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.s1Req && !fits && !ctl.s1Rel) |=> totalOcc == $past(totalOcc));

  // R10: the underflow indication never clears
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflowFlag |=> underflowFlag);

endmodule

// File: rtl/cell_admit_acct.sv
module cell_admit_acct
  import cba_pkg::*;
#(
  parameter int LEN_W      = 14,
  parameter int CELL_BYTES = 208,
  parameter int NUM_PORTS  = 4,
  parameter int POOL_SHIFT = 2,
  parameter int DEF_ING    = 2000,
  parameter int DEF_USER   = 19000,
  parameter int LL_ING     = 8000,
  parameter int LL_USER    = 10000,
  parameter int CPU_CELLS  = 1500,
  parameter int SPAN_CELLS = 1500,
  parameter logic [USER_CLASSES-1:0] NODROP_MASK = 8'h08,
  localparam int MAX_CELLS = ((1 << LEN_W) - 1 + CELL_BYTES - 1) / CELL_BYTES,
  localparam int CELL_W    = $clog2(MAX_CELLS + 1),
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeReq,
  input  logic              reqValid,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [3:0]        reqClass,
  input  logic              reqMcast,
  input  logic [PORT_W-1:0] reqPort,
  input  logic              relValid,
  input  logic [CELL_W-1:0] relCells,
  input  logic [3:0]        relClass,
  input  logic              relMcast,
  input  logic [PORT_W-1:0] relPort,
  output logic              resValid,
  output logic              resAdmit,
  output logic [CELL_W-1:0] resCells,
  output logic              modeActive,
  output logic              modeErr,
  output logic              underflowFlag
);

  ctrl_t ctl;
  logic  allZero;

  cba_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .relValid(relValid),
    .modeReq(modeReq), .allZero(allZero), .ctl(ctl),
    .resValid(resValid), .modeErr(modeErr)
  );

  cba_datapath #(
    .LEN_W(LEN_W), .CELL_BYTES(CELL_BYTES), .NUM_PORTS(NUM_PORTS),
    .POOL_SHIFT(POOL_SHIFT), .DEF_ING(DEF_ING), .DEF_USER(DEF_USER),
    .LL_ING(LL_ING), .LL_USER(LL_USER), .CPU_CELLS(CPU_CELLS),
    .SPAN_CELLS(SPAN_CELLS), .NODROP_MASK(NODROP_MASK),
    .CELL_W(CELL_W), .PORT_W(PORT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .reqValid(reqValid), .reqLen(reqLen), .reqClass(reqClass),
    .reqMcast(reqMcast), .reqPort(reqPort),
    .relValid(relValid), .relCells(relCells), .relClass(relClass),
    .relMcast(relMcast), .relPort(relPort),
    .allZero(allZero), .resAdmit(resAdmit), .resCells(resCells),
    .underflowFlag(underflowFlag)
  );

  assign modeActive = ctl.lossless;

endmodule

// File: tb/tb_cell_admit_acct.sv
module tb_cell_admit_acct;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic modeReq = 1'b0;
  logic reqValid = 1'b0;
  logic [13:0] reqLen = '0;
  logic [3:0] reqClass = '0;
  logic reqMcast = 1'b0;
  logic [1:0] reqPort = '0;
  logic relValid = 1'b0;
  logic [6:0] relCells = '0;
  logic [3:0] relClass = '0;
  logic relMcast = 1'b0;
  logic [1:0] relPort = '0;
  logic resValid, resAdmit, modeActive, modeErr, underflowFlag;
  logic [6:0] resCells;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  // small limits: default ing 8 / user 40 (pool 10) / cpu 6 / span 6;
  // lossless ing 16 (port 4) / user 20 (pool 5); class 3 is no-drop
  cell_admit_acct #(
    .LEN_W(14), .CELL_BYTES(208), .NUM_PORTS(4), .POOL_SHIFT(2),
    .DEF_ING(8), .DEF_USER(40), .LL_ING(16), .LL_USER(20),
    .CPU_CELLS(6), .SPAN_CELLS(6), .NODROP_MASK(8'h08)
  ) dut (
    .clk(clk), .rst_n(rst_n), .modeReq(modeReq),
    .reqValid(reqValid), .reqLen(reqLen), .reqClass(reqClass),
    .reqMcast(reqMcast), .reqPort(reqPort),
    .relValid(relValid), .relCells(relCells), .relClass(relClass),
    .relMcast(relMcast), .relPort(relPort),
    .resValid(resValid), .resAdmit(resAdmit), .resCells(resCells),
    .modeActive(modeActive), .modeErr(modeErr), .underflowFlag(underflowFlag)
  );

  typedef struct packed {
    logic        doReq;
    logic [13:0] len;
    logic [3:0]  cls;
    logic        mc;
    logic [1:0]  port;
    logic        doRel;
    logic [6:0]  rCells;
    logic [3:0]  rCls;
    logic        rMc;
    logic        expA;
    logic [6:0]  expC;
    logic [3:0]  rq;
  } vec_t;

  function automatic vec_t mkReq(int len, int cls, int mc, int port, int a, int c, int id);
    vec_t v;
    v = '0;
    v.doReq = 1'b1; v.len = 14'(len); v.cls = 4'(cls); v.mc = 1'(mc);
    v.port = 2'(port); v.expA = 1'(a); v.expC = 7'(c); v.rq = 4'(id);
    return v;
  endfunction

  function automatic vec_t mkRel(int cells, int cls, int mc);
    vec_t v;
    v = '0;
    v.doRel = 1'b1; v.rCells = 7'(cells); v.rCls = 4'(cls); v.rMc = 1'(mc); v.rq = 4'd9;
    return v;
  endfunction

  function automatic vec_t withRel(vec_t a, vec_t b);
    vec_t v;
    v = a;
    v.doRel = 1'b1; v.rCells = b.rCells; v.rCls = b.rCls; v.rMc = b.rMc;
    return v;
  endfunction

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    mkReq(1,    0, 0, 0, 1, 1, 1),   // R1 tiny packet, one cell
    mkReq(208,  0, 0, 0, 1, 1, 1),   // R1 exact cell
    mkReq(209,  0, 0, 0, 1, 2, 1),   // R1 one byte over; pool0 = 4
    mkReq(0,    1, 1, 0, 1, 1, 1),   // R1 zero length; pool3 = 1
    mkReq(1248, 0, 0, 0, 1, 6, 5),   // R5 pool0 reaches 10 exactly
    mkReq(1,    0, 0, 0, 0, 1, 5),   // R5 pool0 over its share
    mkReq(1,    0, 1, 0, 1, 1, 3),   // R3 multicast pool is separate
    mkReq(1248, 9, 0, 0, 1, 6, 4),   // R4 CPU group full
    mkReq(1,    9, 0, 0, 0, 1, 4),   // R4 CPU over limit
    mkReq(1248, 8, 0, 0, 1, 6, 4),   // R4 SPAN unaffected by full CPU
    mkReq(1,   12, 0, 0, 0, 1, 3),   // R3 invalid class dropped
    withRel(mkReq(1, 9, 0, 0, 1, 1, 9), mkRel(1, 9, 0)), // R9 release first
    mkReq(1,    9, 0, 0, 0, 1, 8),   // R8 earlier drops did not charge
    mkReq(2080, 2, 0, 0, 1, 10, 3),  // R3 user = 22
    mkReq(2080, 2, 1, 0, 1, 10, 3),  // R3 user = 32
    mkReq(1872, 4, 0, 0, 0, 9, 4),   // R4 user would be 41
    mkReq(1664, 4, 0, 0, 1, 8, 4),   // R4 user exactly 40
    mkReq(1,    5, 0, 0, 0, 1, 4),   // R4 empty pool, full group
    mkReq(3,    3, 0, 2, 0, 1, 7),   // R7 no-drop class uses user group in default
    mkRel(10, 0, 0),
    mkRel(1,  0, 1),
    mkRel(1,  1, 1),
    mkRel(10, 2, 0),
    mkRel(10, 2, 1),
    mkRel(8,  4, 0),
    mkRel(6,  9, 0),
    mkRel(6,  8, 0)
  };

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input vec_t v);
    @(negedge clk);
    reqValid = v.doReq; reqLen = v.len; reqClass = v.cls;
    reqMcast = v.mc; reqPort = v.port;
    relValid = v.doRel; relCells = v.rCells; relClass = v.rCls;
    relMcast = v.rMc; relPort = 2'd0;
    @(negedge clk);
    reqValid = 1'b0; relValid = 1'b0;
    if (v.doReq) chk("R2 no early result", int'(resValid), 0);
    @(negedge clk);
    if (v.doReq) begin
      chk("R2 result pulse", int'(resValid), 1);
      chk($sformatf("R%0d admit", v.rq), int'(resAdmit), int'(v.expA));
      chk($sformatf("R%0d cells", v.rq), int'(resCells), int'(v.expC));
    end
  endtask

  task automatic req(input int len, input int cls, input int port, input int a, input int c, input int id);
    run(mkReq(len, cls, 0, port, a, c, id));
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: R2 R10 R11
    chk("R2 reset resValid", int'(resValid), 0);
    chk("R11 reset modeActive", int'(modeActive), 0);
    chk("R11 reset modeErr", int'(modeErr), 0);
    chk("R10 reset underflowFlag", int'(underflowFlag), 0);

    for (int i = 0; i < NV; i++) run(VECS[i]);

    // R9: exact releases never underflow
    chk("R9 releases balanced", int'(underflowFlag), 0);

    // R11: empty buffer accepts the lossless table
    @(negedge clk); modeReq = 1'b1;
    @(negedge clk);
    chk("R11 mode applied", int'(modeActive), 1);
    chk("R11 no error", int'(modeErr), 0);

    // R6: no-drop class 3 goes to ingress reserve, 4 cells per port
    req(832, 3, 0, 1, 4, 6);
    req(1,   3, 0, 0, 1, 6);
    req(832, 3, 1, 1, 4, 6);
    req(208, 3, 2, 1, 1, 6);
    // R7: lossless user pool share is 5
    req(1040, 0, 0, 1, 5, 7);
    req(1,    0, 0, 0, 1, 7);

    // R11: change while occupied is refused
    @(negedge clk); modeReq = 1'b0;
    @(negedge clk);
    chk("R11 change ignored", int'(modeActive), 1);
    chk("R11 error raised", int'(modeErr), 1);
    modeReq = 1'b1;

    // R10: oversize release clamps the empty CPU counter at zero
    run(mkRel(3, 9, 0));
    chk("R10 underflow flagged", int'(underflowFlag), 1);
    req(1248, 9, 0, 1, 6, 10);
    req(1,    9, 0, 0, 1, 10);
    repeat (3) @(negedge clk);
    chk("R10 flag sticky", int'(underflowFlag), 1);

    summary();
    $finish;
  end

endmodule